// File: doc/BRIEF.md
# DTMF Tone-Pair Steering and Code Latch

This block is the digital back end of a dual-tone multi-frequency receiver. Upstream logic separates the low-group tone (697, 770, 852 or 941 Hz, chosen by the keypad row) from the high-group tone (1209, 1336, 1477 or 1633 Hz, chosen by the column). It then raises a presence flag whenever both tones are valid, together with the 4-bit code of the pair. This block decides when that presence is real. It checks how long the tone lasts before registering a key, and how long the pause lasts before releasing the key.

Two guard times, both parameters counted in clock cycles, act as a two-sided hysteresis timer. A presence run that ends before the acquisition guard time is thrown away. A gap inside a tone that ends before the release guard time is bridged, and it neither ends the key nor registers it a second time. On registration the code is captured into a latch and a delayed-steering flag rises. The latch drives a 4-bit output bus gated by an output-enable input. The tri-state bus is modelled as a drive flag plus a data value that reads zero while the bus is not driven.

Top module: `dtmf_steer`

## Requirements
- R1: A key is registered only after `sigPresent` has been sampled high on ACQ_CYCLES consecutive clock edges; `steerOut` rises right after the edge carrying the last of those samples.
- R2: On registration, the `toneCode` value sampled on that last edge is captured into the latch.
- R3: While registered, `steerOut` stays high for as long as `sigPresent` stays high.
- R4: A presence run shorter than ACQ_CYCLES samples registers nothing and leaves the latch unchanged.
- R5: `steerOut` falls right after the edge carrying the REL_CYCLES-th consecutive low sample of `sigPresent`.
- R6: A gap shorter than REL_CYCLES samples keeps `steerOut` high and causes no second capture, even if `toneCode` changes.
- R7: Any change of `sigPresent` before a guard time expires restarts that guard time from zero. For example, two runs of ACQ_CYCLES-1 high samples separated by one low sample register nothing.
- R8: With `outEnable` high, `codeDrive` is 1 and `codeOut` equals the latched code. With `outEnable` low, `codeDrive` is 0 and `codeOut` reads 4'b0000.
- R9: After `steerOut` falls, the latch keeps the last registered code until the next registration.
- R10: Codes pass through unaltered. The encoding is: keys 1..9 map to 0001..1001, '0' to 1010, '*' to 1011, '#' to 1100, A/B/C to 1101/1110/1111, and D to 0000. A, B, C and D sit in the fourth column, and row 4 holds '*', '0', '#', D.
- R11: After reset, `steerOut` is low and the latch holds 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sigPresent | input | 1 | Both valid tones detected this cycle |
| toneCode | input | 4 | Code of the detected tone pair |
| outEnable | input | 1 | Enables the code output bus |
| codeOut | output | 4 | Latched code when enabled, else zero |
| codeDrive | output | 1 | High when the bus is driven |
| steerOut | output | 1 | Delayed steering: a key is registered |

## Verification
The bench builds the block with ACQ_CYCLES = 5 and REL_CYCLES = 3. These values are short enough to hit both guard edges exactly: runs of four versus five high samples, and gaps of two versus three low samples. They also keep every one of the sixteen keypad positions within a short run. The two values differ, so a design that swapped the two guard times or shared a single count would show up at once.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic capture;
  } steerStrobe_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_HELD = 1'b1} steerState_t;
endpackage

// File: rtl/dtmf_steer_dp.sv
module dtmf_steer_dp
  import dtmf_steer_pkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int ACQ_CYCLES = 5,
  parameter int REL_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  steerStrobe_t      strobe,
  input  logic [CODE_W-1:0] toneCode,
  input  logic              outEnable,
  output logic              acqDone,
  output logic              relDone,
  output logic [CODE_W-1:0] latchedCode,
  output logic [CODE_W-1:0] codeOut,
  output logic              codeDrive
);
  localparam int MAX_GUARD = (ACQ_CYCLES > REL_CYCLES) ? ACQ_CYCLES : REL_CYCLES;
  localparam int CNT_W     = $clog2(MAX_GUARD + 1);
  localparam logic [CNT_W-1:0] ACQ_LAST = CNT_W'(ACQ_CYCLES - 1);
  localparam logic [CNT_W-1:0] REL_LAST = CNT_W'(REL_CYCLES - 1);

  logic [CNT_W-1:0]  guardCnt;
  logic [CODE_W-1:0] codeReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      guardCnt <= '0;
    end else if (strobe.cntClear) begin
      guardCnt <= '0;
    end else if (strobe.cntInc) begin
      guardCnt <= guardCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      codeReg <= '0;
    end else if (strobe.capture) begin
      codeReg <= toneCode;
    end
  end

  assign acqDone     = (guardCnt == ACQ_LAST);
  assign relDone     = (guardCnt == REL_LAST);
  assign latchedCode = codeReg;
  assign codeDrive   = outEnable;
  assign codeOut     = outEnable ? codeReg : '0;
endmodule

// File: rtl/dtmf_steer_ctrl.sv
module dtmf_steer_ctrl
  import dtmf_steer_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sigPresent,
  input  logic         acqDone,
  input  logic         relDone,
  output steerStrobe_t strobe,
  output logic         steerOut
);
  steerState_t state, stateNext;

  always_comb begin
    stateNext       = state;
    strobe.cntClear = 1'b0;
    strobe.cntInc   = 1'b0;
    strobe.capture  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (sigPresent) begin
          if (acqDone) begin
            strobe.capture  = 1'b1;
            strobe.cntClear = 1'b1;
            stateNext       = ST_HELD;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end else begin
          strobe.cntClear = 1'b1;
        end
      end
      ST_HELD: begin
        if (!sigPresent) begin
          if (relDone) begin
            strobe.cntClear = 1'b1;
            stateNext       = ST_IDLE;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end else begin
          strobe.cntClear = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign steerOut = (state == ST_HELD);
endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
  import dtmf_steer_pkg::*;
#(
  parameter int ACQ_CYCLES = 5,
  parameter int REL_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sigPresent,
  input  logic [3:0] toneCode,
  input  logic       outEnable,
  output logic [3:0] codeOut,
  output logic       codeDrive,
  output logic       steerOut
);
  steerStrobe_t strobe;
  logic         acqDone;
  logic         relDone;
  logic [3:0]   latchedCode;

  dtmf_steer_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sigPresent (sigPresent),
    .acqDone    (acqDone),
    .relDone    (relDone),
    .strobe     (strobe),
    .steerOut   (steerOut)
  );

  dtmf_steer_dp #(
    .CODE_W     (4),
    .ACQ_CYCLES (ACQ_CYCLES),
    .REL_CYCLES (REL_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .toneCode    (toneCode),
    .outEnable   (outEnable),
    .acqDone     (acqDone),
    .relDone     (relDone),
    .latchedCode (latchedCode),
    .codeOut     (codeOut),
    .codeDrive   (codeDrive)
  );
endmodule

// File: rtl/dtmf_steer_chk.sv
module dtmf_steer_chk #(
  parameter int ACQ_CYCLES = 5,
  parameter int REL_CYCLES = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sigPresent,
  input logic [3:0] toneCode,
  input logic       outEnable,
  input logic [3:0] codeOut,
  input logic       codeDrive,
  input logic       steerOut,
  input logic [3:0] latchedCode
);
  logic [15:0] runHigh;
  logic [15:0] runLow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      runHigh <= '0;
      runLow  <= '0;
    end else begin
      runHigh <= sigPresent ? ((runHigh == 16'hFFFF) ? runHigh : runHigh + 1'b1) : '0;
      runLow  <= sigPresent ? '0 : ((runLow == 16'hFFFF) ? runLow : runLow + 1'b1);
    end
  end

  AST_ACQ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steerOut) |-> (runHigh >= 16'(ACQ_CYCLES))); // R1

  AST_CAPTURE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steerOut) |-> (latchedCode == $past(toneCode))); // R2

  AST_HOLD_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (steerOut && sigPresent) |=> steerOut); // R3

  AST_REL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(steerOut) |-> (runLow >= 16'(REL_CYCLES))); // R5

  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(steerOut) |-> $stable(latchedCode)); // R6

  AST_BUS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !outEnable |-> (!codeDrive && codeOut == 4'b0000)); // R8

  AST_BUS_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    outEnable |-> (codeDrive && codeOut == latchedCode)); // R8
endmodule

bind dtmf_steer dtmf_steer_chk #(
  .ACQ_CYCLES (ACQ_CYCLES),
  .REL_CYCLES (REL_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sigPresent  (sigPresent),
  .toneCode    (toneCode),
  .outEnable   (outEnable),
  .codeOut     (codeOut),
  .codeDrive   (codeDrive),
  .steerOut    (steerOut),
  .latchedCode (latchedCode)
);

// File: tb/dtmf_steer_tb.sv
module dtmf_steer_tb;
  localparam int ACQ = 5;
  localparam int REL = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sigPresent = 1'b0;
  logic [3:0] toneCode = 4'd0;
  logic       outEnable = 1'b1;
  logic [3:0] codeOut;
  logic       codeDrive;
  logic       steerOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  bit       mHeld = 1'b0;
  int       hiRun = 0;
  int       loRun = 0;
  bit [3:0] mLatch = 4'd0;

  always #4 clk = ~clk;

  dtmf_steer #(.ACQ_CYCLES(ACQ), .REL_CYCLES(REL)) u_dut (
    .clk(clk), .rst_n(rst_n), .sigPresent(sigPresent), .toneCode(toneCode),
    .outEnable(outEnable), .codeOut(codeOut), .codeDrive(codeDrive), .steerOut(steerOut)
  );

  function automatic bit [3:0] keyOf(int row, int col);
    if (col == 3) return (row == 3) ? 4'd0 : 4'(13 + row);
    if (row < 3) return 4'(row * 3 + col + 1);
    if (col == 0) return 4'd11;
    if (col == 1) return 4'd10;
    return 4'd12;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    check(tag, steerOut, mHeld, "steerOut");
    check(tag, codeDrive, outEnable, "codeDrive");
    check(tag, codeOut, outEnable ? mLatch : 4'd0, "codeOut");
  endtask

  // apply inputs, advance one edge, update model, compare at negedge
  task automatic step(bit s, bit [3:0] c, bit oe, string tag);
    sigPresent = s;
    toneCode   = c;
    outEnable  = oe;
    @(posedge clk);
    if (!mHeld) begin
      hiRun = s ? hiRun + 1 : 0;
      if (hiRun == ACQ) begin
        mHeld = 1'b1; mLatch = c; hiRun = 0; loRun = 0;
      end
    end else begin
      loRun = s ? 0 : loRun + 1;
      if (loRun == REL) begin
        mHeld = 1'b0; loRun = 0; hiRun = 0;
      end
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", steerOut, 0, "steerOut after reset");
    check("R11", codeOut, 0, "latch after reset");

    // R4: burst one sample short of acquisition
    for (int i = 0; i < ACQ - 1; i++) step(1'b1, 4'd5, 1'b1, "R4");
    for (int i = 0; i < 3; i++) step(1'b0, 4'd0, 1'b1, "R4");
    check("R4", codeOut, 0, "latch after short burst");

    // R1, R2: full acquisition, code changes, last sample wins
    for (int i = 0; i < ACQ - 1; i++) step(1'b1, 4'(i + 1), 1'b1, "R1");
    check("R1", steerOut, 0, "steer before last sample");
    step(1'b1, 4'd9, 1'b1, "R2");
    check("R1", steerOut, 1, "steer after last sample");
    check("R2", codeOut, 9, "captured code");

    // R3: held while present, code changes ignored
    for (int i = 0; i < 6; i++) step(1'b1, 4'd7, 1'b1, "R3");
    check("R3", steerOut, 1, "steer while present");

    // R6: dropout shorter than release, code changes
    for (int i = 0; i < REL - 1; i++) step(1'b0, 4'd3, 1'b1, "R6");
    for (int i = 0; i < ACQ + 1; i++) step(1'b1, 4'd3, 1'b1, "R6");
    check("R6", codeOut, 9, "no second capture");
    check("R6", steerOut, 1, "steer bridged gap");

    // R5: release at exactly REL low samples
    for (int i = 0; i < REL - 1; i++) step(1'b0, 4'd0, 1'b1, "R5");
    check("R5", steerOut, 1, "steer before release");
    step(1'b0, 4'd0, 1'b1, "R5");
    check("R5", steerOut, 0, "steer after release");

    // R9, R8: latch retained, bus gating
    for (int i = 0; i < 4; i++) step(1'b0, 4'd2, 1'(i % 2), "R8");
    step(1'b0, 4'd2, 1'b1, "R9");
    check("R9", codeOut, 9, "latch kept after release");
    step(1'b0, 4'd2, 1'b0, "R8");
    check("R8", codeDrive, 0, "bus off");
    check("R8", codeOut, 0, "bus off reads zero");

    // R7: interrupted acquisition restarts the count
    for (int i = 0; i < ACQ - 1; i++) step(1'b1, 4'd4, 1'b1, "R7");
    step(1'b0, 4'd4, 1'b1, "R7");
    for (int i = 0; i < ACQ - 1; i++) step(1'b1, 4'd4, 1'b1, "R7");
    check("R7", steerOut, 0, "no registration after restart");
    step(1'b0, 4'd4, 1'b1, "R7");
    check("R7", codeOut, 9, "latch untouched");

    // R10: every keypad position
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        for (int i = 0; i < ACQ; i++) step(1'b1, keyOf(r, c), 1'b1, "R10");
        check("R10", codeOut, keyOf(r, c), "key code");
        for (int i = 0; i < REL; i++) step(1'b0, 4'd0, 1'b1, "R10");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule